// File: doc/BRIEF.md
# Three-Lane 7:1 Video Serializer

This block turns a 21-bit parallel pixel word into four serial streams for a flat-panel link. The word holds 18 colour bits (six each of red, green and blue) plus horizontal sync, vertical sync and data enable. One word is taken per pixel clock period. It is spread over three data lanes that each carry seven bits per period. A fourth lane carries a framed clock pattern whose edges mark the word boundary for the receiver.

The pixel clock and a bit clock running at seven times its rate both come from outside the block. The bit clock must be aligned with the pixel clock, and the pixel clock must be high for the first four bit periods of each pixel period. The block finds its serial phase from the pixel clock's falling edge. An active-low power-down input releases all four outputs to high impedance at once. After release, the outputs stay low until a freshly captured word reaches the lanes.

Top module: `vser_tx`

## Requirements
- R1: While rst_ni is low and pd_ni is high, all three data lanes and the clock lane are driven low.
- R2: All 21 input bits are sampled together on the falling edge of the pixel clock. Input changes later in the same pixel period do not alter the word that is sent.
- R3: Word bit k is mapped as follows: red_i[5:0] at bits 0 to 5, green_i[5:0] at 6 to 11, blue_i[5:0] at 12 to 17, hsync_i at 18, vsync_i at 19 and de_i at 20. Data lane j, slot i carries word bit 7*j+i.
- R4: Each pixel period holds seven slots, one per bit clock cycle, slot 0 first. The word captured in pixel period P is sent in period P+1. Slot 0 occupies the bit cycle that starts at the pixel clock's rising edge.
- R5: In every pixel period in which data is sent, the clock lane carries 1,1,0,0,0,1,1 in slots 0 to 6.
- R6: The parallel load into the lane shift registers is timed from each pixel clock falling edge seen in the bit clock domain. Two loads are never adjacent.
- R7: While pd_ni is low, all four outputs are high impedance, with no clock edge needed.
- R8: When reset or power-down is released at the start of a pixel period, the four outputs are driven low for that whole period. The word captured in that period is the first word sent, in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Bit clock, seven times the pixel rate, aligned with the pixel clock |
| clk_pix_i | input | 1 | Pixel clock; its falling edge captures the parallel word |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Active-low power-down |
| red_i | input | 6 | Red colour bits |
| green_i | input | 6 | Green colour bits |
| blue_i | input | 6 | Blue colour bits |
| hsync_i | input | 1 | Line sync |
| vsync_i | input | 1 | Frame sync |
| de_i | input | 1 | Data enable |
| lane_o | output | 3 | Serial data lanes, tri-stated in power-down |
| clk_lane_o | output | 1 | Framed clock lane, tri-stated in power-down |

## Verification
Power-down release and the first capture-and-load after it fall in the same pixel period. The bench releases pd_ni at a pixel rising edge. It expects every lane low for exactly that period, and then the word captured in it, with the framed clock pattern. Power-down is also asserted in periods where a load is due. This shows that the pending word is dropped, the lanes float at once, and no old data leaks out after the next release. A junk word is driven right after each capture edge, so a capture on the wrong edge shows up as inverted data.

// File: rtl/vser_pkg.sv
`timescale 1ns/1ps
package vser_pkg;
  localparam int unsigned COLOR_W        = 6;
  localparam int unsigned LANES          = 3;
  localparam int unsigned WORD_W         = 3*COLOR_W + 3;
  localparam int unsigned SLOTS          = WORD_W / LANES;
  localparam int unsigned PH_W           = $clog2(SLOTS);
  // pixel clock high for this many bit periods at the start of a pixel period
  localparam int unsigned PIX_HIGH_SLOTS = 4;
  // fall seen one cycle late, load one cycle after the phase match
  localparam int unsigned LOAD_PH        = SLOTS - PIX_HIGH_SLOTS - 2;
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/vser_capture.sv
`timescale 1ns/1ps
module vser_capture
  import vser_pkg::*;
(
  input  logic  clk_pix_i,
  input  logic  rst_ni,
  input  word_t word_i,
  output word_t word_o
);
  always_ff @(negedge clk_pix_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= word_i;
  end
endmodule

// File: rtl/vser_phase.sv
`timescale 1ns/1ps
module vser_phase
  import vser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic clk_pix_i,
  output logic fall_o,
  output logic load_o
);
  logic            pix_s_q, pix_d_q, sync_q;
  logic [PH_W-1:0] ph_q;

  assign fall_o = pix_d_q & ~pix_s_q;
  assign load_o = sync_q & pd_ni & (ph_q == PH_W'(LOAD_PH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_s_q <= 1'b0;
      pix_d_q <= 1'b0;
      ph_q    <= '0;
      sync_q  <= 1'b0;
    end else begin
      pix_s_q <= clk_pix_i;
      pix_d_q <= pix_s_q;
      if (fall_o || ph_q == PH_W'(SLOTS-1)) ph_q <= '0;
      else                                  ph_q <= ph_q + 1'b1;
      if (!pd_ni)      sync_q <= 1'b0;
      else if (fall_o) sync_q <= 1'b1;
    end
  end
endmodule

// File: rtl/vser_lane.sv
`timescale 1ns/1ps
module vser_lane
  import vser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= par_i;
    else             sr_q <= {1'b0, sr_q[SLOTS-1:1]};
  end

  assign ser_o = sr_q[0];
endmodule

// File: rtl/vser_tx.sv
`timescale 1ns/1ps
module vser_tx
  import vser_pkg::*;
(
  input  logic               clk_bit_i,
  input  logic               clk_pix_i,
  input  logic               rst_ni,
  input  logic               pd_ni,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  output wire  [LANES-1:0]   lane_o,
  output wire                clk_lane_o
);
  word_t            in_word, cap_word;
  logic             fall, load, clk_ser, out_en_q;
  logic [LANES-1:0] lane_ser;

  assign in_word = {de_i, vsync_i, hsync_i, blue_i, green_i, red_i};

  vser_capture u_cap (
    .clk_pix_i(clk_pix_i),
    .rst_ni   (rst_ni),
    .word_i   (in_word),
    .word_o   (cap_word)
  );

  vser_phase u_phase (
    .clk_i    (clk_bit_i),
    .rst_ni   (rst_ni),
    .pd_ni    (pd_ni),
    .clk_pix_i(clk_pix_i),
    .fall_o   (fall),
    .load_o   (load)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    vser_lane u_lane (
      .clk_i (clk_bit_i),
      .rst_ni(rst_ni),
      .load_i(load),
      .par_i (cap_word[j*SLOTS +: SLOTS]),
      .ser_o (lane_ser[j])
    );
  end

  vser_lane u_clk_lane (
    .clk_i (clk_bit_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .par_i (CLK_PATTERN),
    .ser_o (clk_ser)
  );

  // outputs held low until a fresh word is in the shifters
  always_ff @(posedge clk_bit_i or negedge rst_ni) begin
    if (!rst_ni)    out_en_q <= 1'b0;
    else if (!pd_ni) out_en_q <= 1'b0;
    else if (load)   out_en_q <= 1'b1;
  end

  assign lane_o     = pd_ni ? (out_en_q ? lane_ser : '0) : {LANES{1'bz}};
  assign clk_lane_o = pd_ni ? (out_en_q & clk_ser) : 1'bz;
endmodule

// File: rtl/vser_tx_chk.sv
`timescale 1ns/1ps
module vser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_ni,
  input logic fall_i,
  input logic load_i,
  input logic out_en_i,
  input logic clk_ser_i
);
  assert_load_after_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> $past(fall_i, 2));

  assert_load_not_adjacent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !load_i);

  assert_clk_high_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_ser_i) |=> clk_ser_i);

  assert_clk_low_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_ser_i) |=> !clk_ser_i ##1 !clk_ser_i);

  assert_first_slot_framed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_i) |-> clk_ser_i);

  assert_pd_drops_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !out_en_i);
endmodule

bind vser_tx vser_tx_chk u_chk (
  .clk_i    (clk_bit_i),
  .rst_ni   (rst_ni),
  .pd_ni    (pd_ni),
  .fall_i   (fall),
  .load_i   (load),
  .out_en_i (out_en_q),
  .clk_ser_i(clk_ser)
);

// File: tb/vser_tx_test.sv
`timescale 1ns/1ps
module vser_tx_test;
  import vser_pkg::*;

  localparam int NPER = 260;
  localparam logic [6:0] CLK_EXP = 7'b1100011; // R5: slots 0..6 = 1,1,0,0,0,1,1

  logic clk_bit = 1'b0, clk_pix = 1'b0, rst_n = 1'b0, pd_n = 1'b1;
  logic [COLOR_W-1:0] red = '0, green = '0, blue = '0;
  logic hs = 1'b0, vs = 1'b0, de = 1'b0;
  wire [LANES-1:0] lane_w;
  wire clk_lane_w;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_bit = ~clk_bit;

  vser_tx uut (
    .clk_bit_i(clk_bit), .clk_pix_i(clk_pix), .rst_ni(rst_n), .pd_ni(pd_n),
    .red_i(red), .green_i(green), .blue_i(blue),
    .hsync_i(hs), .vsync_i(vs), .de_i(de),
    .lane_o(lane_w), .clk_lane_o(clk_lane_w)
  );

  task automatic drive_word(input word_t w);
    {de, vs, hs, blue, green, red} = w;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  function automatic word_t pick(input int p);
    if (p == 0) return '0;
    if (p == 1) return '1;
    if (p == 2) return word_t'(21'h0AAAAA);
    if (p == 3) return word_t'(21'h155555);
    if (p >= 4 && p < 4 + WORD_W) return word_t'(1) << (p - 4); // R3 walking one
    return word_t'($urandom);
  endfunction

  function automatic bit pd_sched(input int p);
    if (p == 30 || p == 31 || p == 45) return 1'b0;
    if (p > 60 && ($urandom % 13) == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_cycle(input int p, input int s, input bit pd_now,
                             input bit shown, input word_t wprev);
    for (int j = 0; j < LANES; j++) begin
      string what = $sformatf("period=%0d slot=%0d lane=%0d", p, s, j);
      if (!pd_now)    chk(lane_w[j], 1'bz, "R7", what);
      else if (shown) chk(lane_w[j], wprev[j*SLOTS + s], "R2 R3 R4", what);
      else            chk(lane_w[j], 1'b0, "R8", what);
    end
    begin
      string what = $sformatf("period=%0d slot=%0d clock lane", p, s);
      if (!pd_now)    chk(clk_lane_w, 1'bz, "R7", what);
      else if (shown) chk(clk_lane_w, CLK_EXP[s], "R5 R6", what);
      else            chk(clk_lane_w, 1'b0, "R8", what);
    end
  endtask

  initial begin
    word_t w, prev_w;
    bit pd_now, pd_prev;
    void'($urandom(32'h5EED_0C1A));
    drive_word('0);
    repeat (3) @(negedge clk_bit);
    for (int j = 0; j < LANES; j++) chk(lane_w[j], 1'b0, "R1", $sformatf("reset lane=%0d", j));
    chk(clk_lane_w, 1'b0, "R1", "reset clock lane");
    rst_n = 1'b1;
    prev_w = '0;
    pd_prev = 1'b0;
    for (int p = 0; p < NPER; p++) begin
      pd_now = pd_sched(p);
      w = pick(p);
      for (int s = 0; s < SLOTS; s++) begin
        if (s == 0) begin
          pd_n = pd_now;
          drive_word(w);
          clk_pix = 1'b1;
        end
        if (s == PIX_HIGH_SLOTS) clk_pix = 1'b0;
        if (s == PIX_HIGH_SLOTS + 1) drive_word(~w); // R2: after capture, must be ignored
        @(posedge clk_bit);
        @(negedge clk_bit);
        check_cycle(p, s, pd_now, pd_prev && (p > 0), prev_w);
      end
      prev_w = w;
      pd_prev = pd_now;
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule